// File: doc/BRIEF.md
# UART Loopback Self-Test Sequencer

This block runs a built-in self-test on a UART that sits next to it. Software writes a start command into an 8-bit control/status register. The sequencer then switches the UART into internal loopback and pushes a run of pseudo-random bytes into the transmit FIFO. The bytes come from a maximal-length 8-bit LFSR, and a private copy of each one is kept. The sequencer waits for the transmit path to drain and for the receive FIFO to fill. It then pops every received byte and compares it, in order, with the stored copy.

Each phase of the run sets its own progress bit in the register, so after a failure software can tell how far the test got. A receiver error flag seen at any point in the run is latched in a separate bit. A pass/fail bit reports the byte comparison. A timeout ends a run that stops making progress, with the pass bit left clear. The UART side uses a byte write port with a full flag, a byte read port with an empty flag (the head byte is visible before the pop), a transmit-idle flag, a receive-full flag and a loopback select.

Top module: `serial_selftest`

## Requirements
- R1: After reset, the control/status register reads 0x00 and loopback select is low. Neither the transmit write strobe nor the receive read strobe is active.
- R2: A register write with bit 7 set, made while no test is running, starts a test. From the next cycle the register reads exactly 0x80, so bits 6 to 0 are cleared. Loopback select is high on every cycle in which bit 7 reads 1.
- R3: Each test writes exactly DEPTH bytes (16 by default) to the transmit port. The first byte is 0x01. Each later byte is the previous one shifted left by one place, with bit 0 filled by the XOR of bits 7, 5, 4 and 3 of the previous byte. No byte is zero, and no write happens while the transmit-full flag is high.
- R4: Bit 6 sets after the last pattern byte is written. Bit 5 sets when the transmit-idle flag is then seen high. Bit 4 sets when the receive-full flag is seen high. A bit never sets before the bits of the earlier phases.
- R5: Comparison begins only after bit 4 has set, and bit 3 sets with the first pop. DEPTH bytes are popped, and never while the receive-empty flag is high. At the end, bit 0 is 1 only if every popped byte equals the byte written in the same position.
- R6: Bit 2 sets if the receiver error input is high on any cycle of a running test. It has no effect on bit 0.
- R7: When a test ends, bit 7 clears and loopback select falls. The other bits keep their result until the next start.
- R8: If TIMEOUT cycles pass during a run with no byte moved and no phase change, the test ends with bit 0 and bit 7 clear. The progress bits keep the last phase reached.
- R9: A start write while a test is running is ignored. A write with bit 7 clear does nothing. Bit 1 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data (bit 7 = start) |
| reg_rdata | output | 8 | Control/status register contents |
| loop_sel | output | 1 | Puts the UART in internal loopback |
| tx_wr_en | output | 1 | Push tx_wr_data into the transmit FIFO |
| tx_wr_data | output | DATA_W | Pattern byte for the transmit FIFO |
| tx_full | input | 1 | Transmit FIFO full |
| tx_empty | input | 1 | Transmit FIFO and shifter idle |
| rx_rd_en | output | 1 | Pop the receive FIFO head |
| rx_rd_data | input | DATA_W | Receive FIFO head byte |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_full | input | 1 | Receive FIFO full |
| rx_err | input | 1 | Receiver error flag (parity, framing, overrun, break) |

## Verification
The assertions check the handshake rules on every cycle: no pushes while the transmit FIFO is full, no pops while the receive FIFO is empty, no zero pattern byte, and writes only during loading. They also check that loopback select follows the run bit, that the progress bits set in phase order, and that the register clears on start and latches the error flag. Only the bench scenarios can show the exact byte sequence and that bit 0 reflects an injected corruption. The same holds for a dropped byte that ends in a timeout, a stalled transmit FIFO, and start writes that are ignored.

// File: rtl/selftest_pkg.sv
package selftest_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LOAD,
        PH_DRAIN,
        PH_RECV,
        PH_CMP
    } phase_e;

    // Bit order is software-visible: start is bit 7, pass is bit 0.
    typedef struct packed {
        logic start;
        logic loaded;
        logic sent;
        logic rcvd;
        logic cmp;
        logic err;
        logic spare;
        logic pass;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    function automatic ctl_t ctl_on_start();
        ctl_t c;
        c       = '0;
        c.start = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/selftest_lfsr.sv
module selftest_lfsr #(
    parameter int             W     = 8,
    parameter logic [W-1:0]   TAPS  = 8'hB8,
    parameter logic [W-1:0]   SEED  = 8'h01
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         reseed,
    input  logic         step,
    output logic [W-1:0] value
);
    logic feedback;

    assign feedback = ^(value & TAPS);

    always_ff @(posedge clk) begin
        if (rst || reseed) begin
            value <= SEED;
        end else if (step) begin
            value <= {value[W-2:0], feedback};
        end
    end
endmodule

// File: rtl/selftest_store.sv
module selftest_store #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data
);
    logic [W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                mem[g] <= wr_data;
            end
        end
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/selftest_seq.sv
module selftest_seq
    import selftest_pkg::*;
#(
    parameter int W       = 8,
    parameter int DEPTH   = 16,
    parameter int TIMEOUT = 4096,
    parameter int IDX_W   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_we,
    input  logic [CTL_W-1:0] host_wdata,
    input  logic             tx_full,
    input  logic             tx_empty,
    input  logic             rx_full,
    input  logic             rx_empty,
    input  logic             rx_err,
    input  logic [W-1:0]     rx_data,
    input  logic [W-1:0]     ref_data,
    output ctl_t             ctl,
    output logic             loop_sel,
    output logic             start_cmd,
    output logic             tx_wr_en,
    output logic             rx_rd_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_idx
);
    localparam int               TMO_W    = $clog2(TIMEOUT + 1);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DEPTH - 1);

    phase_e           phase;
    logic [TMO_W-1:0] tmo;
    logic             miss;
    logic             byte_bad;
    logic             advance;

    assign start_cmd = (phase == PH_IDLE) && host_we && host_wdata[CTL_W-1];
    assign tx_wr_en  = (phase == PH_LOAD) && !tx_full;
    assign rx_rd_en  = (phase == PH_CMP)  && !rx_empty;
    assign loop_sel  = (phase != PH_IDLE);
    assign byte_bad  = (rx_data != ref_data);
    assign advance   = tx_wr_en || rx_rd_en ||
                       ((phase == PH_DRAIN) && tx_empty) ||
                       ((phase == PH_RECV)  && rx_full);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            ctl    <= '0;
            wr_idx <= '0;
            rd_idx <= '0;
            miss   <= 1'b0;
            tmo    <= '0;
        end else begin
            if (phase != PH_IDLE && rx_err) begin
                ctl.err <= 1'b1;
            end
            if (phase == PH_IDLE || advance) begin
                tmo <= '0;
            end else begin
                tmo <= tmo + 1'b1;
            end

            unique case (phase)
                PH_IDLE: begin
                    if (start_cmd) begin
                        ctl    <= ctl_on_start();
                        wr_idx <= '0;
                        rd_idx <= '0;
                        miss   <= 1'b0;
                        phase  <= PH_LOAD;
                    end
                end
                PH_LOAD: begin
                    if (tx_wr_en) begin
                        wr_idx <= wr_idx + 1'b1;
                        if (wr_idx == IDX_LAST) begin
                            ctl.loaded <= 1'b1;
                            phase      <= PH_DRAIN;
                        end
                    end
                end
                PH_DRAIN: begin
                    if (tx_empty) begin
                        ctl.sent <= 1'b1;
                        phase    <= PH_RECV;
                    end
                end
                PH_RECV: begin
                    if (rx_full) begin
                        ctl.rcvd <= 1'b1;
                        phase    <= PH_CMP;
                    end
                end
                PH_CMP: begin
                    if (rx_rd_en) begin
                        ctl.cmp <= 1'b1;
                        rd_idx  <= rd_idx + 1'b1;
                        if (rd_idx == IDX_LAST) begin
                            ctl.pass  <= !(miss || byte_bad);
                            ctl.start <= 1'b0;
                            phase     <= PH_IDLE;
                        end else if (byte_bad) begin
                            miss <= 1'b1;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase

            if (phase != PH_IDLE && !advance && tmo == TMO_LAST) begin
                ctl.start <= 1'b0;
                ctl.pass  <= 1'b0;
                phase     <= PH_IDLE;
            end
        end
    end
endmodule

// File: rtl/serial_selftest.sv
module serial_selftest
    import selftest_pkg::*;
#(
    parameter int           DATA_W  = 8,
    parameter int           DEPTH   = 16,
    parameter int           TIMEOUT = 4096,
    parameter logic [7:0]   TAPS    = 8'hB8,
    parameter logic [7:0]   SEED    = 8'h01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              loop_sel,
    output logic              tx_wr_en,
    output logic [DATA_W-1:0] tx_wr_data,
    input  logic              tx_full,
    input  logic              tx_empty,
    output logic              rx_rd_en,
    input  logic [DATA_W-1:0] rx_rd_data,
    input  logic              rx_empty,
    input  logic              rx_full,
    input  logic              rx_err
);
    localparam int IDX_W = $clog2(DEPTH);

    ctl_t              ctl;
    logic              start_cmd;
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_idx;
    logic [DATA_W-1:0] pattern;
    logic [DATA_W-1:0] ref_byte;

    selftest_lfsr #(
        .W    (DATA_W),
        .TAPS (DATA_W'(TAPS)),
        .SEED (DATA_W'(SEED))
    ) u_lfsr (
        .clk    (clk),
        .rst    (rst),
        .reseed (start_cmd),
        .step   (tx_wr_en),
        .value  (pattern)
    );

    selftest_store #(
        .W     (DATA_W),
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tx_wr_en),
        .wr_idx  (wr_idx),
        .wr_data (pattern),
        .rd_idx  (rd_idx),
        .rd_data (ref_byte)
    );

    selftest_seq #(
        .W       (DATA_W),
        .DEPTH   (DEPTH),
        .TIMEOUT (TIMEOUT),
        .IDX_W   (IDX_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .host_we    (reg_we),
        .host_wdata (reg_wdata),
        .tx_full    (tx_full),
        .tx_empty   (tx_empty),
        .rx_full    (rx_full),
        .rx_empty   (rx_empty),
        .rx_err     (rx_err),
        .rx_data    (rx_rd_data),
        .ref_data   (ref_byte),
        .ctl        (ctl),
        .loop_sel   (loop_sel),
        .start_cmd  (start_cmd),
        .tx_wr_en   (tx_wr_en),
        .rx_rd_en   (rx_rd_en),
        .wr_idx     (wr_idx),
        .rd_idx     (rd_idx)
    );

    assign tx_wr_data = pattern;
    assign reg_rdata  = ctl;
endmodule

// File: rtl/serial_selftest_checker.sv
module serial_selftest_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [7:0]        reg_wdata,
    input logic [7:0]        reg_rdata,
    input logic              loop_sel,
    input logic              tx_wr_en,
    input logic [DATA_W-1:0] tx_wr_data,
    input logic              tx_full,
    input logic              rx_rd_en,
    input logic              rx_empty,
    input logic              rx_err
);
    assert_loop_while_running_R2: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[7] |-> loop_sel);

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (!reg_rdata[7] && reg_we && reg_wdata[7]) |=> (reg_rdata == 8'h80));

    assert_no_write_full_R3: assert property (@(posedge clk) disable iff (rst)
        tx_wr_en |-> !tx_full);

    assert_pattern_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
        tx_wr_en |-> (tx_wr_data != '0));

    assert_write_only_loading_R4: assert property (@(posedge clk) disable iff (rst)
        tx_wr_en |-> (reg_rdata[7] && !reg_rdata[6]));

    assert_phase_order_R4: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[4] |-> (reg_rdata[5] && reg_rdata[6]));

    assert_cmp_after_rcvd_R5: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[3] |-> reg_rdata[4]);

    assert_no_read_empty_R5: assert property (@(posedge clk) disable iff (rst)
        rx_rd_en |-> !rx_empty);

    assert_pass_needs_cmp_R5: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[0] |-> reg_rdata[3]);

    assert_err_latched_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[7] && rx_err) |=> reg_rdata[2]);

    assert_loop_off_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !reg_rdata[7] |-> !loop_sel);
endmodule

bind serial_selftest serial_selftest_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .loop_sel   (loop_sel),
    .tx_wr_en   (tx_wr_en),
    .tx_wr_data (tx_wr_data),
    .tx_full    (tx_full),
    .rx_rd_en   (rx_rd_en),
    .rx_empty   (rx_empty),
    .rx_err     (rx_err)
);

// File: tb/serial_selftest_test.sv
`timescale 1ns/1ps
module serial_selftest_test;
    localparam int N   = 16;
    localparam int LAT = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       loop_sel, tx_wr_en, rx_rd_en;
    logic [7:0] tx_wr_data;
    logic       tx_full = 1'b0, tx_empty = 1'b1;
    logic       rx_empty = 1'b1, rx_full = 1'b0, rx_err = 1'b0;
    logic [7:0] rx_rd_data = '0;

    int tests = 0, fails = 0;

    serial_selftest uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .loop_sel(loop_sel), .tx_wr_en(tx_wr_en),
        .tx_wr_data(tx_wr_data), .tx_full(tx_full), .tx_empty(tx_empty),
        .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data), .rx_empty(rx_empty),
        .rx_full(rx_full), .rx_err(rx_err)
    );

    always #2.5 clk = ~clk;

    // UART loopback model
    logic [7:0] txq [$];
    logic [7:0] rxq [$];
    logic [7:0] tx_log [N];
    int tx_cnt = 0, deliv = 0, bcnt = 0;
    int corrupt_at = -1, drop_at = -1;
    int wr_full_cnt = 0, rd_empty_cnt = 0;
    logic stall_full = 1'b0;

    always @(posedge clk) begin
        logic [7:0] b;
        if (rst) begin
            txq.delete();
            rxq.delete();
            bcnt = 0;
            tx_full    <= 1'b0;
            tx_empty   <= 1'b1;
            rx_full    <= 1'b0;
            rx_empty   <= 1'b1;
            rx_rd_data <= '0;
        end else begin
            if (tx_wr_en) begin
                if (tx_full) wr_full_cnt++;
                txq.push_back(tx_wr_data);
                if (tx_cnt < N) tx_log[tx_cnt] = tx_wr_data;
                tx_cnt++;
            end
            if (rx_rd_en) begin
                if (rxq.size() == 0) rd_empty_cnt++;
                else void'(rxq.pop_front());
            end
            if (txq.size() != 0) begin
                bcnt++;
                if (bcnt >= LAT) begin
                    b = txq.pop_front();
                    if (deliv == corrupt_at) b = b ^ 8'h10;
                    if (deliv != drop_at) rxq.push_back(b);
                    deliv++;
                    bcnt = 0;
                end
            end
            tx_full    <= stall_full || (txq.size() >= N);
            tx_empty   <= (txq.size() == 0);
            rx_full    <= (rxq.size() >= N);
            rx_empty   <= (rxq.size() == 0);
            rx_rd_data <= (rxq.size() != 0) ? rxq[0] : 8'h00;
        end
    end

    // continuous monitors sampled away from the active edge
    int loop_bad = 0, order_bad = 0, spare_bad = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (reg_rdata[7] != loop_sel) loop_bad++;
            if (reg_rdata[4] && !(reg_rdata[5] && reg_rdata[6])) order_bad++;
            if (reg_rdata[3] && !reg_rdata[4]) order_bad++;
            if (reg_rdata[1]) spare_bad++;
        end
    end

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic model_clear();
        @(negedge clk);
        txq.delete();
        rxq.delete();
        bcnt = 0; tx_cnt = 0; deliv = 0;
        corrupt_at = -1; drop_at = -1;
        wr_full_cnt = 0; rd_empty_cnt = 0;
        loop_bad = 0; order_bad = 0; spare_bad = 0;
        @(negedge clk);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 10000 && reg_rdata[7]; i++) @(negedge clk);
    endtask

    task automatic check_patterns(input string req);
        logic [7:0] e = 8'h01;
        int bad = 0;
        check(tx_cnt == N, req, tx_cnt, N);
        for (int i = 0; i < N; i++) begin
            if (tx_log[i] != e) bad++;
            e = {e[6:0], e[7] ^ e[5] ^ e[4] ^ e[3]};
        end
        check(bad == 0, req, bad, 0);
    endtask

    task automatic check_end(input logic [7:0] exp, input string req);
        check(reg_rdata == exp, req, reg_rdata, exp);
        check(!loop_sel, "R7", loop_sel, 0);
        check(wr_full_cnt == 0 && rd_empty_cnt == 0, "R3/R5 handshake",
              wr_full_cnt + rd_empty_cnt, 0);
        check(loop_bad == 0, "R2 loop select", loop_bad, 0);
        check(order_bad == 0, "R4 order", order_bad, 0);
        check(spare_bad == 0, "R9 bit1", spare_bad, 0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(reg_rdata == 8'h00, "R1 register", reg_rdata, 0);
        check(!loop_sel && !tx_wr_en && !rx_rd_en, "R1 strobes",
              {loop_sel, tx_wr_en, rx_rd_en}, 0);
    endtask

    task automatic test_pass();
        model_clear();
        host_write(8'h80);
        check(reg_rdata == 8'h80, "R2 start clears", reg_wdata, 8'h80);
        check(loop_sel, "R2 loopback", loop_sel, 1);
        wait_done();
        check_patterns("R3 sequence");
        check_end(8'h79, "R5 pass");
    endtask

    task automatic test_restart_clears();
        model_clear();
        host_write(8'hFF);
        check(reg_rdata == 8'h80, "R2 restart clears", reg_rdata, 8'h80);
        wait_done();
        check_end(8'h79, "R7 end");
    endtask

    task automatic test_stall();
        model_clear();
        stall_full = 1'b1;
        host_write(8'h80);
        repeat (30) @(negedge clk);
        check(tx_cnt == 0, "R3 stall", tx_cnt, 0);
        stall_full = 1'b0;
        wait_done();
        check_patterns("R3 after stall");
        check_end(8'h79, "R3 stall result");
    endtask

    task automatic test_corrupt();
        model_clear();
        corrupt_at = 3;
        host_write(8'h80);
        wait_done();
        check_end(8'h78, "R5 mismatch");
    endtask

    task automatic test_error_flag();
        model_clear();
        host_write(8'h80);
        repeat (40) @(negedge clk);
        rx_err = 1'b1;
        @(negedge clk);
        rx_err = 1'b0;
        check(reg_rdata[2], "R6 latched", reg_rdata, 8'h04);
        wait_done();
        check_end(8'h7D, "R6 pass kept");
    endtask

    task automatic test_timeout();
        model_clear();
        drop_at = 5;
        host_write(8'h80);
        wait_done();
        check_end(8'h60, "R8 timeout");
        model_clear();
    endtask

    task automatic test_ignored_writes();
        model_clear();
        host_write(8'h80);
        repeat (4) @(negedge clk);
        host_write(8'h80);
        host_write(8'h7F);
        check(reg_rdata[7] && !reg_rdata[0], "R9 busy write", reg_rdata, 8'h80);
        wait_done();
        check_patterns("R9 no restart");
        check_end(8'h79, "R9 result");
        host_write(8'h02);
        repeat (3) @(negedge clk);
        check(reg_rdata == 8'h79 && !loop_sel, "R9 idle write", reg_rdata, 8'h79);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_pass();
        test_restart_clears();
        test_stall();
        test_corrupt();
        test_error_flag();
        test_timeout();
        test_ignored_writes();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule